// File: doc/BRIEF.md
# Ping-Pong Playback DMA Address Engine

This block generates memory read addresses for an audio playback path. Software programs two independent memory areas, each with a start address and a byte length. It picks the sample format and then sets a run bit. The engine then reads area 1, then area 2, then area 1 again, for as long as the run bit stays set. Each time an area finishes, the engine sets a completion flag for that area. A global status bit and an interrupt pin summarise those flags, and software acknowledges them by writing ones.

Reads go out through a request/grant pair. The engine holds the request and its address steady until a grant arrives. Each grant advances the position by one sample frame, which is 1, 2 or 4 bytes depending on the format. Software can read back both the current absolute address and the byte offset inside the area being played. It can pause at any point and resume from the same address.

Register words are 16 bits wide. The register bus uses a write strobe and a byte offset. Read data is registered: it appears one clock after the offset is presented.

Top module: `pingpong_play_dma`

## Requirements
- R1: After reset the following registers read 0x0000: control (0x00), flags (0x02), position low and high (0x10, 0x12) and offset (0x14). The format register (0x16) reads 0x0010, and mem_req is low.
- R2: Control bit 0 (run) is the only bit that starts the engine. The first run after reset loads the area-1 start address and requests there. mem_req is never asserted while run is 0.
- R3: A request stays asserted with a stable mem_addr until it is granted. Each grant advances the address and offset by the frame size. Format bit 4 selects 16-bit samples and bit 5 selects two channels, which gives a step of 1 (neither set), 2 (either one set) or 4 (both set).
- R4: When offset plus step reaches or passes the current area length, the address in that same cycle becomes the other area's start and the offset becomes 0. Finishing area 1 sets flag bit 1, finishing area 2 sets flag bit 2, and the two areas alternate indefinitely.
- R5: An area whose length is 0 is skipped without issuing any request, and its completion flag is still set.
- R6: Clearing run freezes the position and offset, and no grant has any effect while paused. Setting run again continues from the frozen address.
- R7: Flags are cleared by writing a 1 to them (write-one-to-clear). Writing 0xFFFF to 0x02 clears every flag at once.
- R8: Control bits 15:6, flag bits 15:5 and format bits 15:6 always read 0, and writes to those bits are ignored.
- R9: The current address reads back as two words, bits 15:0 at 0x10 and bits 31:16 at 0x12. The offset within the current area reads back at 0x14.
- R10: The irq pin and bit 0 of the global status register (0x64) are high exactly while flag bit 1 or flag bit 2 is set.
- R11: Area start addresses are written as a low word and a high word: area 1 at 0x04/0x06 and area 2 at 0x08/0x0A. Byte lengths are at 0x0C (area 1) and 0x0E (area 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (even) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's reg_addr |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested frame |
| mem_gnt | input | 1 | Grant; advances the engine by one frame |
| irq | output | 1 | High while any area-completion flag is pending |

## Verification
The hardest case to reach is an area of length zero that is skipped in the middle of a running sequence. Nothing about it is visible on the request port except that an address does not appear. The bench reaches it by setting area 1 to length zero while the engine is paused inside area 2. It then lets two rounds run under the scoreboard, which would flag any request at the area-1 start as a mismatch. Finally it reads back the area-1 flag, which only the skip can have set.

Pause behaviour is exercised in a similar way. The bench offers grants while run is low, where any accepted grant would show up as an unexpected scoreboard item. It then checks that resuming continues from the frozen address.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] A_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] A_FLAGS = 8'h02;
  localparam logic [REG_AW-1:0] A_START = 8'h04; // area i low word at A_START + 4*i
  localparam logic [REG_AW-1:0] A_LEN   = 8'h0C; // area i length at A_LEN + 2*i
  localparam logic [REG_AW-1:0] A_POSL  = 8'h10;
  localparam logic [REG_AW-1:0] A_POSH  = 8'h12;
  localparam logic [REG_AW-1:0] A_OFS   = 8'h14;
  localparam logic [REG_AW-1:0] A_FMT   = 8'h16;
  localparam logic [REG_AW-1:0] A_GSTAT = 8'h64;

  localparam logic [5:0] FMT_RESET = 6'h10;

  // bytes per sample frame from width and channel flags
  function automatic logic [2:0] frame_step(input logic wide, input logic dual);
    case ({wide, dual})
      2'b00:   frame_step = 3'd1;
      2'b11:   frame_step = 3'd4;
      default: frame_step = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [REG_DW-1:0]   wdata,
  output logic [REG_DW-1:0]   rdata,
  output logic                run,
  output logic                fmt_wide,
  output logic                fmt_dual,
  output logic [ADDR_W-1:0]   start_a,
  output logic [ADDR_W-1:0]   start_b,
  output logic [LEN_W-1:0]    len_a,
  output logic [LEN_W-1:0]    len_b,
  input  logic [1:0]          done,
  input  logic [ADDR_W-1:0]   pos,
  input  logic [LEN_W-1:0]    ofs,
  output logic                irq
);
  localparam int NAREA = 2;

  logic [5:0] ctrl_q;
  logic [4:0] flag_q;
  logic [5:0] fmt_q;
  logic [ADDR_W-1:0] start_w [NAREA];
  logic [LEN_W-1:0]  len_w   [NAREA];
  logic [4:0] ack;
  logic [REG_DW-1:0] rd_mux;
  logic unused_bits;

  assign unused_bits = ^wdata[15:6];

  // one start/length register set per area
  for (genvar i = 0; i < NAREA; i++) begin : g_area
    localparam logic [REG_AW-1:0] LO_ADR  = A_START + REG_AW'(4 * i);
    localparam logic [REG_AW-1:0] HI_ADR  = A_START + REG_AW'(4 * i + 2);
    localparam logic [REG_AW-1:0] LEN_ADR = A_LEN + REG_AW'(2 * i);
    logic [ADDR_W-1:0] s_q;
    logic [LEN_W-1:0]  l_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= '0;
        l_q <= '0;
      end else if (we) begin
        if (addr == LO_ADR)  s_q[15:0] <= wdata;
        if (addr == HI_ADR)  s_q[ADDR_W-1:16] <= wdata[ADDR_W-17:0];
        if (addr == LEN_ADR) l_q <= wdata[LEN_W-1:0];
      end
    end
    assign start_w[i] = s_q;
    assign len_w[i]   = l_q;
  end

  assign ack = (we && addr == A_FLAGS) ? wdata[4:0] : 5'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
      fmt_q  <= FMT_RESET;
    end else begin
      if (we && addr == A_CTRL) ctrl_q <= wdata[5:0];
      if (we && addr == A_FMT)  fmt_q  <= wdata[5:0];
      // hardware set wins over a same-cycle acknowledge
      flag_q <= (flag_q & ~ack) | {2'b00, done, 1'b0};
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_mux = {10'b0, ctrl_q};
      A_FLAGS: rd_mux = {11'b0, flag_q};
      A_POSL:  rd_mux = pos[15:0];
      A_POSH:  rd_mux = REG_DW'(pos >> 16);
      A_OFS:   rd_mux = REG_DW'(ofs);
      A_FMT:   rd_mux = {10'b0, fmt_q};
      A_GSTAT: rd_mux = {15'b0, irq};
      default: begin
        rd_mux = '0;
        for (int i = 0; i < NAREA; i++) begin
          if (addr == A_START + REG_AW'(4 * i))     rd_mux = start_w[i][15:0];
          if (addr == A_START + REG_AW'(4 * i + 2)) rd_mux = REG_DW'(start_w[i] >> 16);
          if (addr == A_LEN + REG_AW'(2 * i))       rd_mux = REG_DW'(len_w[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign run      = ctrl_q[0];
  assign fmt_wide = fmt_q[4];
  assign fmt_dual = fmt_q[5];
  assign start_a  = start_w[0];
  assign start_b  = start_w[1];
  assign len_a    = len_w[0];
  assign len_b    = len_w[1];
  assign irq      = flag_q[1] | flag_q[2];
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fmt_wide,
  input  logic              fmt_dual,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] start_b,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  input  logic              gnt,
  output logic              req,
  output logic [ADDR_W-1:0] pos,
  output logic [LEN_W-1:0]  ofs,
  output logic [1:0]        done
);
  logic              area_q;   // 0: first area, 1: second area
  logic              loaded_q; // a start address has been taken since reset
  logic [LEN_W-1:0]  cur_len;
  logic [ADDR_W-1:0] next_start;
  logic [2:0]        step;
  logic [LEN_W:0]    ofs_nxt;
  logic              active;
  logic              at_end;

  assign step       = frame_step(fmt_wide, fmt_dual);
  assign cur_len    = area_q ? len_b : len_a;
  assign next_start = area_q ? start_a : start_b;
  assign ofs_nxt    = {1'b0, ofs} + (LEN_W + 1)'(step);
  assign active     = run && loaded_q;
  assign req        = active && (cur_len != '0);
  assign at_end     = active && ((cur_len == '0) || (gnt && ofs_nxt >= {1'b0, cur_len}));
  assign done       = at_end ? (area_q ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      area_q   <= 1'b0;
      loaded_q <= 1'b0;
      pos      <= '0;
      ofs      <= '0;
    end else if (run && !loaded_q) begin
      loaded_q <= 1'b1;
      area_q   <= 1'b0;
      pos      <= start_a;
      ofs      <= '0;
    end else if (at_end) begin
      area_q <= ~area_q;
      pos    <= next_start;
      ofs    <= '0;
    end else if (req && gnt) begin
      pos <= pos + ADDR_W'(step);
      ofs <= ofs_nxt[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/pingpong_play_dma.sv
module pingpong_play_dma
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  output logic              irq
);
  logic              run_w;
  logic              wide_w;
  logic              dual_w;
  logic [ADDR_W-1:0] sa_w;
  logic [ADDR_W-1:0] sb_w;
  logic [LEN_W-1:0]  la_w;
  logic [LEN_W-1:0]  lb_w;
  logic [LEN_W-1:0]  ofs_w;
  logic [1:0]        done_w;

  pp_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .run(run_w), .fmt_wide(wide_w), .fmt_dual(dual_w),
    .start_a(sa_w), .start_b(sb_w), .len_a(la_w), .len_b(lb_w),
    .done(done_w), .pos(mem_addr), .ofs(ofs_w), .irq(irq)
  );

  pp_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .run(run_w), .fmt_wide(wide_w), .fmt_dual(dual_w),
    .start_a(sa_w), .start_b(sb_w), .len_a(la_w), .len_b(lb_w),
    .gnt(mem_gnt), .req(mem_req), .pos(mem_addr), .ofs(ofs_w), .done(done_w)
  );
endmodule

// File: rtl/pp_play_dma_chk.sv
module pp_play_dma_chk
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_rdata,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq,
  input logic              run,
  input logic [1:0]        done
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !reg_we) |=> (mem_req && $stable(mem_addr)));

  // R2
  no_req_paused_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mem_req);

  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !reg_we) |=> $stable(mem_addr));

  // R8
  flags_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_FLAGS) |=> (reg_rdata[15:5] == 11'b0));

  // R10
  irq_summary_chk: assert property (@(posedge clk) disable iff (rst)
    (done != 2'b00) |=> irq);
endmodule

bind pingpong_play_dma pp_play_dma_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .irq(irq), .run(run_w), .done(done_w)
);

// File: tb/sim_pingpong_play_dma.sv
`timescale 1ns/1ps
module sim_pingpong_play_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        irq;

  logic [31:0] exp_q [$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          gnt_en = 1'b0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  pingpong_play_dma u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: choose grant for the coming edge, pop and compare accepted frames
  always @(negedge clk) begin
    bit g;
    cyc++;
    g = gnt_en && (cyc % 3 != 1);
    mem_gnt = g;
    if (g && mem_req && !rst) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R3/R6 unexpected grant accepted", mem_addr, 32'hFFFFFFFF);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e, "R3/R4 granted address", mem_addr, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // driver: expected addresses for one pass over an area
  task automatic push_area(input logic [31:0] s, input int len, input int step);
    for (int o = 0; o < len; o += step) exp_q.push_back(s + 32'(o));
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    gnt_en = 1'b1;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(posedge clk);
      guard++;
    end
    gnt_en = 1'b0;
    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R1..R11 unfinished)");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rd(8'h00, v); chk(v == 16'h0000, "R1 control reset", 32'(v), 32'h0);
    rd(8'h02, v); chk(v == 16'h0000, "R1 flags reset", 32'(v), 32'h0);
    rd(8'h10, v); chk(v == 16'h0000, "R1 position low reset", 32'(v), 32'h0);
    rd(8'h12, v); chk(v == 16'h0000, "R1 position high reset", 32'(v), 32'h0);
    rd(8'h14, v); chk(v == 16'h0000, "R1 offset reset", 32'(v), 32'h0);
    rd(8'h16, v); chk(v == 16'h0010, "R1 format reset", 32'(v), 32'h10);
    chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 0);

    // R11 program both areas; 16-bit mono gives step 2
    wr(8'h04, 16'h0000); wr(8'h06, 16'h0001);
    wr(8'h08, 16'h0100); wr(8'h0A, 16'h0002);
    wr(8'h0C, 16'd8);    wr(8'h0E, 16'd6);
    rd(8'h0A, v); chk(v == 16'h0002, "R11 area-2 start high readback", 32'(v), 32'h2);
    rd(8'h0E, v); chk(v == 16'd6, "R11 area-2 length readback", 32'(v), 6);
    chk(mem_req == 1'b0, "R2 no request before run", 32'(mem_req), 0);

    push_area(32'h0001_0000, 8, 2); push_area(32'h0002_0100, 6, 2);
    push_area(32'h0001_0000, 8, 2); push_area(32'h0002_0100, 6, 2);
    exp_q.push_back(32'h0001_0000);
    wr(8'h00, 16'h0001);
    drain();

    // R4 both areas finished; R10 summary
    rd(8'h02, v); chk(v == 16'h0006, "R4 both completion flags", 32'(v), 32'h6);
    rd(8'h64, v); chk(v == 16'h0001, "R10 global status bit", 32'(v), 32'h1);
    chk(irq == 1'b1, "R10 irq pin high", 32'(irq), 1);
    // R9 position and offset after one frame into area 1
    rd(8'h10, v); chk(v == 16'h0002, "R9 position low", 32'(v), 32'h2);
    rd(8'h12, v); chk(v == 16'h0001, "R9 position high", 32'(v), 32'h1);
    rd(8'h14, v); chk(v == 16'h0002, "R9 offset in area", 32'(v), 32'h2);
    // R3 request held without grant
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b1 && mem_addr == 32'h0001_0002, "R3 request held stable",
        mem_addr, 32'h0001_0002);

    // R7 write-one-to-clear
    wr(8'h02, 16'h0002);
    rd(8'h02, v); chk(v == 16'h0004, "R7 clear only area-1 flag", 32'(v), 32'h4);
    wr(8'h02, 16'hFFFF);
    rd(8'h02, v); chk(v == 16'h0000, "R7 clear all flags", 32'(v), 32'h0);
    chk(irq == 1'b0, "R10 irq low after clear", 32'(irq), 0);
    rd(8'h64, v); chk(v == 16'h0000, "R10 global status clear", 32'(v), 32'h0);

    // R6 pause: grants offered must be ignored
    wr(8'h00, 16'h0000);
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0, "R2/R6 no request while paused", 32'(mem_req), 0);
    gnt_en = 1'b1;
    repeat (10) @(negedge clk);
    gnt_en = 1'b0;
    rd(8'h10, v); chk(v == 16'h0002, "R6 position frozen", 32'(v), 32'h2);
    rd(8'h14, v); chk(v == 16'h0002, "R6 offset frozen", 32'(v), 32'h2);
    push_area(32'h0001_0002, 6, 2);
    wr(8'h00, 16'h0001);
    drain();
    rd(8'h02, v); chk(v == 16'h0002, "R4/R6 area-1 flag after resume", 32'(v), 32'h2);

    // R5 zero-length area 1 skipped; R3 16-bit stereo step 4
    wr(8'h00, 16'h0000);
    wr(8'h02, 16'hFFFF);
    wr(8'h16, 16'h0030);
    wr(8'h0E, 16'd12);
    wr(8'h0C, 16'd0);
    push_area(32'h0002_0100, 12, 4); push_area(32'h0002_0100, 12, 4);
    wr(8'h00, 16'h0001);
    drain();
    rd(8'h02, v); chk(v == 16'h0006, "R5 skipped area still flags", 32'(v), 32'h6);

    // R3 8-bit mono step 1
    wr(8'h00, 16'h0000);
    wr(8'h16, 16'h0000);
    wr(8'h0E, 16'd3);
    push_area(32'h0002_0100, 3, 1);
    wr(8'h00, 16'h0001);
    drain();

    // R3 8-bit stereo step 2
    wr(8'h00, 16'h0000);
    wr(8'h16, 16'h0020);
    wr(8'h0E, 16'd4);
    push_area(32'h0002_0100, 4, 2);
    wr(8'h00, 16'h0001);
    drain();

    // R8 read-only bits
    wr(8'h00, 16'hFFFE);
    rd(8'h00, v); chk(v == 16'h003E, "R8 control upper bits", 32'(v), 32'h3E);
    wr(8'h02, 16'hFFFF);
    rd(8'h02, v); chk(v == 16'h0000, "R8 flag upper bits", 32'(v), 32'h0);
    wr(8'h16, 16'hFFFF);
    rd(8'h16, v); chk(v == 16'h003F, "R8 format upper bits", 32'(v), 32'h3F);
    chk(mem_req == 1'b0, "R2 bits 5:1 do not run", 32'(mem_req), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule